// File: doc/BRIEF.md
# Inbound Mailbox Queue with Status and Data Interrupt

This block holds a short queue of 32-bit messages that a responder pushes in from one side. A host processor drains the queue through a window of 32-bit registers. The host can consume the oldest word, look at it without consuming it, and read a status word that flags the queue as full or empty. A small configuration register holds the data-interrupt enable and shows a live pending bit. These two bits drive a level interrupt towards the host.

The same window also has a read-only status view of the companion outbound queue. That queue's occupancy enters as an input and is encoded in the same way as the inbound status. Every slot that holds no message, whether it was never filled or has been emptied, contains the invalid marker 0xFFFFFFFF.

Top module: `inbox_mailbox`

## Requirements
- R1: A read at offset 0x98 returns the inbound status word. Bit 31 is 1 exactly when the count equals DEPTH (8), bit 30 is 1 exactly when the count is 0, and all other bits read 0. A read at 0xB8 returns a word with the same encoding, built from the `out_count` input.
- R2: After reset the count is 0 and the config register is 0. Every slot holds 0xFFFFFFFF and `irq` is low.
- R3: When `resp_valid` is high and the queue is below DEPTH at the clock edge, `resp_data` is appended at the tail. When the queue is full at that edge, the push has no effect.
- R4: A read strobe at offsets 0x80, 0x84, 0x88 or 0x8C on a non-empty queue returns the head word and removes it. Every later word moves one slot towards the head, and the tail slot that is vacated becomes 0xFFFFFFFF.
- R5: A read strobe in the pop window while the queue is empty returns 0xFFFFFFFF and changes no state.
- R6: A read at 0x90 returns the head slot and does not remove it. On an empty queue it returns 0xFFFFFFFF.
- R7: A write to 0x9C loads only bit 0, the data-interrupt enable, from the write data. A read of 0x9C returns the enable in bit 0 and, in bit 4, a pending flag that is 1 whenever the queue is non-empty. All other bits read 0.
- R8: `irq` is a registered output. After each clock edge it equals the enable AND the non-empty condition as they stood before that edge.
- R9: Only address bits 7:2 are decoded. A read at 0x94 returns 0, and so does a read at any unlisted offset. Writes to any offset other than 0x9C have no effect.
- R10: When a pop and an accepted push happen in the same cycle, the head leaves and the new word lands in the slot just behind the last remaining word. The count is unchanged. On a full queue the push in that cycle is still refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| resp_valid | input | 1 | Push request from the responder side |
| resp_data | input | 32 | Word to push |
| out_count | input | CNT_W | Occupancy of the outbound queue |
| irq | output | 1 | Level data-available interrupt |

## Verification
The bench aims at the queue edges. It pops an empty queue, which a faulty design would answer with stale data or with a count that wraps. It pushes into a full queue, where a faulty design would overwrite the tail. It pops and pushes in the same cycle both on a full queue and on a partly filled one, where a wrong write position leaves a hole or duplicates a word. It also checks that the vacated tail slot shows the marker, that only bit 0 of the config register takes writes, that aliased high address bits decode to the same register, and that `irq` rises exactly one cycle after the queue becomes non-empty with the enable set.

// File: rtl/inbox_mailbox.sv
module inbox_mailbox #(
  parameter int          DEPTH    = 8,
  parameter int          ADDR_W   = 12,
  parameter logic [31:0] SENTINEL = 32'hFFFF_FFFF,
  localparam int         CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              resp_valid,
  input  logic [31:0]       resp_data,
  input  logic [CNT_W-1:0]  out_count,
  output logic              irq
);

  localparam logic [5:0] W_PEEK   = 6'h24;
  localparam logic [5:0] W_SENDER = 6'h25;
  localparam logic [5:0] W_STAT   = 6'h26;
  localparam logic [5:0] W_CFG    = 6'h27;
  localparam logic [5:0] W_OSTAT  = 6'h2E;
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [31:0]      slot    [DEPTH];
  logic [31:0]      shifted [DEPTH];
  logic [CNT_W-1:0] cnt;
  logic             cfg_en;

  wire [5:0]       word     = bus_addr[7:2];
  wire             in_popw  = word[5:2] == 4'h8;
  wire             is_empty = cnt == '0;
  wire             is_full  = cnt == FULL_CNT;
  wire             pop      = bus_rd && in_popw && !is_empty;
  wire             push     = resp_valid && !is_full;
  wire [CNT_W-1:0] wpos     = pop ? cnt - 1'b1 : cnt;

  function automatic logic [31:0] status_of(input logic [CNT_W-1:0] c);
    return {c == FULL_CNT, c == '0, 30'b0};
  endfunction

  for (genvar g = 0; g < DEPTH; g++) begin : g_shift
    if (g == DEPTH - 1) begin : g_tail
      assign shifted[g] = SENTINEL;
    end else begin : g_body
      assign shifted[g] = slot[g+1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      cfg_en <= 1'b0;
      irq    <= 1'b0;
      for (int i = 0; i < DEPTH; i++) slot[i] <= SENTINEL;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (push && wpos == CNT_W'(i)) slot[i] <= resp_data;
        else if (pop)                  slot[i] <= shifted[i];
      end
      cnt <= cnt + CNT_W'(push) - CNT_W'(pop);
      if (bus_wr && word == W_CFG) cfg_en <= bus_wdata[0];
      irq <= cfg_en && !is_empty;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (in_popw) bus_rdata = is_empty ? SENTINEL : slot[0];
    else begin
      case (word)
        W_PEEK:   bus_rdata = slot[0];
        W_SENDER: bus_rdata = '0;
        W_STAT:   bus_rdata = status_of(cnt);
        W_CFG:    bus_rdata = {27'b0, !is_empty, 3'b0, cfg_en};
        W_OSTAT:  bus_rdata = status_of(out_count);
        default:  bus_rdata = '0;
      endcase
    end
  end

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL_CNT);

  assert_full_push_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (is_full && resp_valid && !(bus_rd && in_popw)) |=> (is_full && $stable(slot[DEPTH-1])));

  assert_empty_pop_noop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (is_empty && bus_rd && in_popw && !resp_valid) |=> (is_empty && $stable(slot[0])));

  assert_pop_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !resp_valid && cnt > 1) |=> slot[0] == $past(slot[1]));

  assert_tail_sentinel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && is_full) |=> slot[DEPTH-1] == SENTINEL);

  assert_swap_keeps_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && push) |=> $stable(cnt));

  assert_cfg_write_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && word == W_CFG) |=> $stable(cfg_en));

  assert_irq_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> !irq);

  assert_irq_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && !is_empty) |=> irq);

endmodule

// File: tb/inbox_mailbox_test.sv
module inbox_mailbox_test;
  localparam int DEPTH = 8;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [31:0] SENT = 32'hFFFF_FFFF;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [11:0]       bus_addr = '0;
  logic              bus_rd = 1'b0, bus_wr = 1'b0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic              resp_valid = 1'b0;
  logic [31:0]       resp_data = '0;
  logic [CNT_W-1:0]  out_count = '0;
  logic              irq;

  int checks = 0, errors = 0;
  logic [31:0] q[$];
  bit en = 0, irq_exp = 0;

  inbox_mailbox #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .resp_valid(resp_valid),
    .resp_data(resp_data), .out_count(out_count), .irq(irq));

  always #10 clk = ~clk;

  function automatic logic [31:0] stat(input int c);
    return {c == DEPTH, c == 0, 30'b0};
  endfunction

  function automatic logic [31:0] exp_rd(input logic [11:0] a);
    case (a[7:0] & 8'hFC)
      8'h80, 8'h84, 8'h88, 8'h8C: return q.size() == 0 ? SENT : q[0];
      8'h90: return q.size() == 0 ? SENT : q[0];
      8'h98: return stat(q.size());
      8'h9C: return {27'b0, q.size() != 0, 3'b0, en};
      8'hB8: return stat(int'(out_count));
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [11:0] a);
    case (a[7:0] & 8'hFC)
      8'h80, 8'h84, 8'h88, 8'h8C: return q.size() == 0 ? "R5" : "R4";
      8'h90: return "R6";
      8'h98, 8'hB8: return "R1";
      8'h9C: return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input bit rd, input bit wr, input logic [11:0] a,
                      input logic [31:0] wd, input bit pv, input logic [31:0] pd);
    bit popping, pushing, nirq;
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd;
    resp_valid = pv; resp_data = pd;
    #1;
    if (rd) check(tag_of(a), bus_rdata, exp_rd(a));
    check("R8", {31'b0, irq}, {31'b0, irq_exp});
    popping = rd && (a[7:4] == 4'h8) && q.size() > 0;
    pushing = pv && q.size() < DEPTH;
    nirq    = en && q.size() != 0;
    @(posedge clk);
    if (popping) void'(q.pop_front());
    if (pushing) q.push_back(pd);
    if (wr && (a[7:0] & 8'hFC) == 8'h9C) en = wd[0];
    irq_exp = nirq;
    @(negedge clk);
    bus_rd = 0; bus_wr = 0; resp_valid = 0;
  endtask

  task automatic rd_at(input logic [11:0] a);  step(1, 0, a, 0, 0, 0); endtask
  task automatic wr_at(input logic [11:0] a, input logic [31:0] d); step(0, 1, a, d, 0, 0); endtask
  task automatic push(input logic [31:0] d); step(0, 0, 12'h0, 0, 1, d); endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R2: reset state seen at the ports
    check("R2", {31'b0, irq}, 32'h0);
    rd_at(12'h098); rd_at(12'h090); rd_at(12'h09C); rd_at(12'h080);
    // R3 pushes, R6 peek keeps head, R7 pending
    push(32'h0000_0011); push(32'h0000_0022); push(32'h0000_0033);
    rd_at(12'h090); rd_at(12'h090); rd_at(12'h098); rd_at(12'h09C);
    // R7 only bit 0 writable; R8 irq one cycle later
    wr_at(12'h09C, 32'hFFFF_FFFF); rd_at(12'h09C); rd_at(12'h094);
    wr_at(12'h09C, 32'hFFFF_FFFE); rd_at(12'h09C);
    wr_at(12'h39C, 32'h0000_0001); rd_at(12'h09C);
    // R4 pop through each alias of the window
    rd_at(12'h084); rd_at(12'h08C);
    // R3 fill to full then push refused
    for (int i = 0; i < 8; i++) push(32'hA000_0000 + i);
    rd_at(12'h098);
    push(32'hDEAD_BEEF); rd_at(12'h098);
    // R10 swap on full: push refused
    step(1, 0, 12'h088, 0, 1, 32'hBAD0_0001); rd_at(12'h098);
    // R4 vacated slot shows marker after draining
    while (q.size() > 1) rd_at(12'h080);
    // R10 swap with one entry
    step(1, 0, 12'h080, 0, 1, 32'h5555_0001); rd_at(12'h090); rd_at(12'h080);
    // R5 empty pop: marker, no change
    rd_at(12'h080); rd_at(12'h098); rd_at(12'h090);
    // R9 masking, unlisted offsets and ignored writes
    push(32'h1234_5678);
    wr_at(12'h080, 32'h0); wr_at(12'h090, 32'h0); wr_at(12'h098, 32'h0);
    rd_at(12'h398); rd_at(12'h190); rd_at(12'h0A0); rd_at(12'h000); rd_at(12'h0FC);
    // R1 outbound status view
    out_count = 0; rd_at(12'h0B8);
    out_count = 3; rd_at(12'h0B8);
    out_count = CNT_W'(DEPTH); rd_at(12'h2B8);
    // mixed traffic against the model
    for (int n = 0; n < 600; n++) begin
      logic [11:0] a;
      case ($urandom_range(0, 7))
        0, 1, 2: a = 12'h080 + 12'(4 * $urandom_range(0, 3));
        3: a = 12'h090;
        4: a = 12'h098;
        5: a = 12'h09C;
        6: a = 12'h0B8;
        default: a = 12'(4 * $urandom_range(0, 63));
      endcase
      step($urandom_range(0, 1) == 1, $urandom_range(0, 9) == 0, a, $urandom,
           $urandom_range(0, 2) != 0, $urandom);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule